// File: doc/BRIEF.md
# Endian-Aware External Bus Sizer

This block connects a 32-bit internal master to an external memory port whose device is 8, 16 or 32 bits wide. The master presents a byte address, an access size (byte, word or longword), a direction and, for writes, a right-justified data value. The sizer breaks the access into as many back-to-back external cycles as the device width requires. It places every byte on the device lane that the selected byte order calls for, drives one active-low write strobe per lane, and gathers read bytes back into a right-justified internal word.

Byte order is taken from a mode pin while the power-on reset is held, and it stays fixed until the next reset. Each external sub-cycle lasts exactly one clock. The block answers with a one-cycle acknowledge once the final sub-cycle is over. A request that is not aligned to its own size is refused with a one-cycle error pulse and produces no external activity.

Top module: `ext_bus_sizer`

## Requirements
- R1: While `rst` is high, `mode_pin` is sampled: 0 selects big-endian, 1 selects little-endian. Changes on `mode_pin` while `rst` is low have no effect.
- R2: Device width code `dev_width` 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 32-bit. Access size code `req_size` 00 = byte, 01 = word, 10 = longword, 11 = longword. An aligned request of S bytes on a W-byte device runs max(1, S/W) consecutive one-clock external cycles, with `ext_cyc` high only during them and `ext_wr` equal to the request direction.
- R3: Sub-cycle k (counting from 0) presents `ext_addr` = request address + k·W.
- R4: Lane L carries `ext_wdata`/`ext_rdata` bits 8L+7..8L. On a W-byte device the byte at address a uses lane W−1−(a mod W) in big-endian mode and lane (a mod W) in little-endian mode; lanes at or above W are never used.
- R5: For a value of S bytes, the byte at request address + j is the value byte S−1−j in big-endian mode and value byte j in little-endian mode, so the first sub-cycle carries the most significant bytes in big-endian mode and the least significant bytes in little-endian mode.
- R6: `ext_wstb_n` is active low, one bit per lane; during a write sub-cycle exactly the lanes carrying bytes are low (min(S, W) of them), and all bits are high on read sub-cycles and when idle.
- R7: Read data appears on `rdata` right-justified and zero-extended above the access size, valid in the cycle `ack` is high.
- R8: `ack` is high for exactly one cycle, the cycle that follows the last external sub-cycle, and never earlier.
- R9: A word at an odd address or a longword at an address not a multiple of 4 raises `err` for one cycle, in the cycle after the request, with no external cycle, no write and no `ack`.
- R10: A `req` that arrives while sub-cycles are running is ignored: it causes no external cycle, no write and no extra `ack`.
- R11: After reset `ack`, `err` and `ext_cyc` are low and `ext_wstb_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode_pin | input | 1 | Byte order select, sampled during reset |
| dev_width | input | 2 | Static device width code |
| req | input | 1 | One-cycle request pulse, taken when idle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write value |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle misalignment pulse |
| rdata | output | 32 | Right-justified read value, valid with ack |
| ext_cyc | output | 1 | External sub-cycle in progress |
| ext_wr | output | 1 | Sub-cycle is a write |
| ext_addr | output | ADDR_W | Byte address of the sub-cycle |
| ext_wdata | output | 32 | Lane-mapped write data |
| ext_wstb_n | output | 4 | Active-low per-lane write strobes |
| ext_rdata | input | 32 | Device read data on lanes |

## Verification
Two functions can meet in one cycle: the acknowledge of a finished access and the arrival of a new request, and likewise a running access and a fresh request pulse that must be ignored. The bench provokes the second by pulsing a write request to an unrelated address during the first sub-cycle of a four-cycle longword read on a byte-wide device, then judges that exactly four sub-cycles with the expected addresses appear, one acknowledge follows, the bus stays idle afterwards and the unrelated byte of the device model is unchanged. Every size, offset and width pairing is swept in both byte orders through a byte-array device model whose contents are compared against an arithmetic reference after each write.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        DW_8    = 2'b00,
        DW_16   = 2'b01,
        DW_32   = 2'b10,
        DW_RSVD = 2'b11
    } dev_width_e;

    typedef enum logic {
        END_BIG    = 1'b0,
        END_LITTLE = 1'b1
    } endian_e;

    // Decoded request: byte counts, sub-cycle count and alignment verdict
    typedef struct packed {
        logic [2:0] acc_bytes;
        logic [2:0] dev_bytes;
        logic [2:0] n_cyc;
        logic       misaligned;
    } plan_t;

    function automatic logic [2:0] size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] width_bytes(dev_width_e w);
        case (w)
            DW_8:    return 3'd1;
            DW_16:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic is_misaligned(acc_size_e s, logic [1:0] lo);
        case (s)
            SZ_BYTE: return 1'b0;
            SZ_WORD: return lo[0];
            default: return |lo;
        endcase
    endfunction

    function automatic logic [2:0] sub_cycles(logic [2:0] a, logic [2:0] d);
        if (a <= d)       return 3'd1;
        else if (d == 3'd1) return a;
        else              return a >> 1;
    endfunction

    // Device lane used by the byte at offset 'off' within the device word
    function automatic logic [1:0] lane_for(endian_e e, logic [2:0] d, logic [1:0] off);
        case (d)
            3'd1:    return 2'd0;
            3'd2:    return {1'b0, (e == END_BIG) ? ~off[0] : off[0]};
            default: return (e == END_BIG) ? ~off : off;
        endcase
    endfunction

    // Byte index inside the right-justified value for access byte j
    function automatic logic [1:0] value_byte(endian_e e, logic [2:0] a, logic [1:0] j);
        logic [2:0] t;
        t = a - 3'd1 - {1'b0, j};
        return (e == END_BIG) ? t[1:0] : j;
    endfunction

    function automatic logic [LANES-1:0] lane_span(logic [2:0] d);
        case (d)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/bsz_req_decode.sv
module bsz_req_decode
    import bsz_pkg::*;
(
    input  logic [1:0] size_code,
    input  logic [1:0] width_code,
    input  logic [1:0] addr_lo,
    output plan_t      plan
);
    logic [2:0] a_bytes;
    logic [2:0] d_bytes;

    always_comb begin
        a_bytes         = size_bytes(acc_size_e'(size_code));
        d_bytes         = width_bytes(dev_width_e'(width_code));
        plan.acc_bytes  = a_bytes;
        plan.dev_bytes  = d_bytes;
        plan.n_cyc      = sub_cycles(a_bytes, d_bytes);
        plan.misaligned = is_misaligned(acc_size_e'(size_code), addr_lo);
    end
endmodule

// File: rtl/bsz_lane_map.sv
module bsz_lane_map
    import bsz_pkg::*;
(
    input  endian_e           endian,
    input  logic [2:0]        acc_bytes,
    input  logic [2:0]        dev_bytes,
    input  logic [1:0]        idx,
    input  logic [1:0]        base_lo,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lane_rdata,
    input  logic [DATA_W-1:0] accum,
    output logic [DATA_W-1:0] lane_wdata,
    output logic [LANES-1:0]  lane_used,
    output logic [DATA_W-1:0] accum_next
);
    logic [2:0] per_cyc;
    logic [1:0] start;
    logic [1:0] j;
    logic [1:0] lane;
    logic [1:0] vb;

    always_comb begin
        per_cyc = (acc_bytes < dev_bytes) ? acc_bytes : dev_bytes;
        case (dev_bytes)
            3'd1:    start = idx;
            3'd2:    start = {idx[0], 1'b0};
            default: start = 2'd0;
        endcase
    end

    always_comb begin
        lane_wdata = '0;
        lane_used  = '0;
        accum_next = accum;
        j          = '0;
        lane       = '0;
        vb         = '0;
        for (int i = 0; i < LANES; i++) begin
            if (3'(i) < per_cyc) begin
                j    = start + 2'(i);
                lane = lane_for(endian, dev_bytes, base_lo + j);
                vb   = value_byte(endian, acc_bytes, j);
                lane_wdata[{lane, 3'b000} +: BYTE_W] = value[{vb, 3'b000} +: BYTE_W];
                lane_used[lane]                      = 1'b1;
                accum_next[{vb, 3'b000} +: BYTE_W]   = lane_rdata[{lane, 3'b000} +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  plan_t             plan_in,
    input  logic [DATA_W-1:0] accum_next,
    output logic              busy,
    output logic              we_q,
    output logic [1:0]        idx_q,
    output logic [2:0]        acc_bytes_q,
    output logic [2:0]        dev_bytes_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] accum_q,
    output logic              ack,
    output logic              err
);
    logic [2:0]        n_cyc_q;
    logic [ADDR_W-1:0] step;
    logic              last_sub;

    always_comb begin
        case (dev_bytes_q)
            3'd1:    step = ADDR_W'(idx_q);
            3'd2:    step = ADDR_W'({idx_q, 1'b0});
            default: step = ADDR_W'({idx_q, 2'b00});
        endcase
        sub_addr = base_q + step;
        last_sub = ({1'b0, idx_q} == (n_cyc_q - 3'd1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            we_q        <= 1'b0;
            idx_q       <= '0;
            acc_bytes_q <= 3'd1;
            dev_bytes_q <= 3'd1;
            n_cyc_q     <= 3'd1;
            base_q      <= '0;
            wdata_q     <= '0;
            accum_q     <= '0;
            ack         <= 1'b0;
            err         <= 1'b0;
        end else begin
            ack <= 1'b0;
            err <= 1'b0;
            if (!busy) begin
                if (req) begin
                    if (plan_in.misaligned) begin
                        err <= 1'b1;
                    end else begin
                        busy        <= 1'b1;
                        we_q        <= req_we;
                        idx_q       <= '0;
                        acc_bytes_q <= plan_in.acc_bytes;
                        dev_bytes_q <= plan_in.dev_bytes;
                        n_cyc_q     <= plan_in.n_cyc;
                        base_q      <= req_addr;
                        wdata_q     <= req_wdata;
                        accum_q     <= '0;
                    end
                end
            end else begin
                if (!we_q) accum_q <= accum_next;
                if (last_sub) begin
                    busy <= 1'b0;
                    ack  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 2'd1;
                end
            end
        end
    end

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R8
    ack_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> ($past(busy) && !busy));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(base_q));

    // R2
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ({1'b0, idx_q} < n_cyc_q));
endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_pin,
    input  logic [1:0]        dev_width,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [31:0]       req_wdata,
    output logic              ack,
    output logic              err,
    output logic [31:0]       rdata,
    output logic              ext_cyc,
    output logic              ext_wr,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [31:0]       ext_wdata,
    output logic [3:0]        ext_wstb_n,
    input  logic [31:0]       ext_rdata
);
    endian_e           endian_q;
    plan_t             plan;
    logic              busy;
    logic              we_q;
    logic [1:0]        idx_q;
    logic [2:0]        acc_bytes_q;
    logic [2:0]        dev_bytes_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] sub_addr;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] accum_q;
    logic [DATA_W-1:0] accum_next;
    logic [DATA_W-1:0] lane_wdata;
    logic [LANES-1:0]  lane_used;
    logic              wr_phase;

    // Byte order is captured only while power-on reset is held
    always_ff @(posedge clk) begin
        if (rst) endian_q <= endian_e'(mode_pin);
    end

    bsz_req_decode dec_i (
        .size_code  (req_size),
        .width_code (dev_width),
        .addr_lo    (req_addr[1:0]),
        .plan       (plan)
    );

    bsz_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .req_addr    (req_addr),
        .req_we      (req_we),
        .req_wdata   (req_wdata),
        .plan_in     (plan),
        .accum_next  (accum_next),
        .busy        (busy),
        .we_q        (we_q),
        .idx_q       (idx_q),
        .acc_bytes_q (acc_bytes_q),
        .dev_bytes_q (dev_bytes_q),
        .base_q      (base_q),
        .sub_addr    (sub_addr),
        .wdata_q     (wdata_q),
        .accum_q     (accum_q),
        .ack         (ack),
        .err         (err)
    );

    bsz_lane_map map_i (
        .endian     (endian_q),
        .acc_bytes  (acc_bytes_q),
        .dev_bytes  (dev_bytes_q),
        .idx        (idx_q),
        .base_lo    (base_q[1:0]),
        .value      (wdata_q),
        .lane_rdata (ext_rdata),
        .accum      (accum_q),
        .lane_wdata (lane_wdata),
        .lane_used  (lane_used),
        .accum_next (accum_next)
    );

    always_comb begin
        wr_phase   = busy && we_q;
        ext_cyc    = busy;
        ext_wr     = wr_phase;
        ext_addr   = sub_addr;
        ext_wdata  = wr_phase ? lane_wdata : '0;
        ext_wstb_n = ~(lane_used & {LANES{wr_phase}});
        rdata      = accum_q;
    end

    // R1
    endian_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(endian_q));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!ext_cyc && !ack));

    // R4
    lane_range_chk: assert property (@(posedge clk) disable iff (rst)
        ext_wr |-> ((~ext_wstb_n & ~lane_span(dev_bytes_q)) == 4'b0000));

    // R6
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_cyc |-> (ext_wstb_n == 4'b1111));
endmodule

// File: tb/ext_bus_sizer_tb_top.sv
module ext_bus_sizer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_pin = 1'b0;
    logic [1:0]  dev_width = 2'b10;
    logic        req = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        ack, err, ext_cyc, ext_wr;
    logic [31:0] rdata, ext_addr, ext_wdata, ext_rdata;
    logic [3:0]  ext_wstb_n;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  w_b   = 4;
    bit  be_b  = 1;
    logic [7:0] mem     [0:63];
    logic [7:0] ref_mem [0:63];

    always #5 clk = ~clk;

    ext_bus_sizer #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst(rst), .mode_pin(mode_pin), .dev_width(dev_width),
        .req(req), .req_addr(req_addr), .req_size(req_size), .req_we(req_we),
        .req_wdata(req_wdata), .ack(ack), .err(err), .rdata(rdata),
        .ext_cyc(ext_cyc), .ext_wr(ext_wr), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_wstb_n(ext_wstb_n), .ext_rdata(ext_rdata)
    );

    // Device model: lane L of a W-byte device word holds the byte at
    // aligned address + (W-1-L) for big-endian, + L for little-endian
    always_comb begin
        int al;
        ext_rdata = 32'hEEEE_EEEE;
        al = int'(ext_addr[5:0]) & ~(w_b - 1);
        for (int l = 0; l < 4; l++) begin
            if (l < w_b) ext_rdata[l*8 +: 8] = mem[(al + (be_b ? w_b - 1 - l : l)) & 63];
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic int mem_diffs();
        int d = 0;
        for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) d++;
        return d;
    endfunction

    task automatic do_op(input int sz, input int addr, input bit we,
                         input logic [31:0] v, input bit intrude);
        int s, n, cnt, al, pos;
        bit mis;
        logic [31:0] exp;
        s   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        mis = (s == 2 && (addr % 2) != 0) || (s == 4 && (addr % 4) != 0);
        n   = (s <= w_b) ? 1 : s / w_b;
        exp = '0;
        for (int j = 0; j < s; j++) begin
            pos = be_b ? s - 1 - j : j;
            exp[pos*8 +: 8] = ref_mem[addr + j];
        end
        @(negedge clk);
        req = 1; req_size = 2'(sz); req_addr = addr; req_we = we; req_wdata = v;
        @(negedge clk);
        req = 0;
        if (mis) begin
            chk(err === 1'b1, "R9 error pulse", {31'b0, err}, 1);
            chk(ext_cyc === 1'b0 && ack === 1'b0, "R9 no external cycle", {30'b0, ext_cyc, ack}, 0);
            @(negedge clk);
            chk(err === 1'b0 && ext_cyc === 1'b0 && ack === 1'b0, "R9 error lasts one cycle",
                {29'b0, err, ext_cyc, ack}, 0);
            chk(mem_diffs() == 0, "R9 no device write", mem_diffs(), 0);
            return;
        end
        for (int k = 0; k < n; k++) begin
            if (intrude && k == 0) begin
                req = 1; req_addr = 40; req_we = 1; req_size = 2'd0; req_wdata = 32'h77;
            end
            if (intrude && k == 1) req = 0;
            chk(ext_cyc === 1'b1, "R2 sub-cycle active", {31'b0, ext_cyc}, 1);
            chk(ext_wr === we, "R2 sub-cycle direction", {31'b0, ext_wr}, {31'b0, we});
            chk(ext_addr === 32'(addr + k * w_b), "R3 sub-cycle address", ext_addr, 32'(addr + k * w_b));
            chk(ack === 1'b0, "R8 no early ack", {31'b0, ack}, 0);
            if (we) begin
                cnt = 0;
                al  = int'(ext_addr[5:0]) & ~(w_b - 1);
                for (int l = 0; l < 4; l++) begin
                    if (ext_wstb_n[l] === 1'b0) begin
                        cnt++;
                        if (l >= w_b) chk(0, "R4 strobe beyond device lanes", l, w_b);
                        else mem[(al + (be_b ? w_b - 1 - l : l)) & 63] = ext_wdata[l*8 +: 8];
                    end
                end
                chk(cnt == ((s < w_b) ? s : w_b), "R6 strobe count", cnt, (s < w_b) ? s : w_b);
            end else begin
                chk(ext_wstb_n === 4'hF, "R6 strobes high on read", {28'b0, ext_wstb_n}, 32'hF);
            end
            @(negedge clk);
        end
        req = 0;
        chk(ack === 1'b1, "R8 ack after last sub-cycle", {31'b0, ack}, 1);
        chk(ext_cyc === 1'b0, "R2 no extra sub-cycle", {31'b0, ext_cyc}, 0);
        if (!we) begin
            chk(rdata === exp, "R7 R5 R4 read data", rdata, exp);
        end else begin
            for (int j = 0; j < s; j++) begin
                pos = be_b ? s - 1 - j : j;
                ref_mem[addr + j] = v[pos*8 +: 8];
            end
            chk(mem_diffs() == 0, "R5 R4 written bytes", mem_diffs(), 0);
        end
        @(negedge clk);
        chk(ack === 1'b0, "R8 ack single cycle", {31'b0, ack}, 0);
        if (intrude) begin
            for (int q = 0; q < 3; q++) begin
                chk(ext_cyc === 1'b0 && ack === 1'b0, "R10 busy request ignored",
                    {30'b0, ext_cyc, ack}, 0);
                @(negedge clk);
            end
            chk(mem[40] === ref_mem[40], "R10 no stray write", {24'b0, mem[40]}, {24'b0, ref_mem[40]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        for (int e = 0; e < 2; e++) begin
            rst = 1; mode_pin = e[0]; be_b = (e == 0);
            repeat (3) @(negedge clk);
            rst = 0;
            @(negedge clk);
            // R11
            chk(ack === 0 && err === 0 && ext_cyc === 0, "R11 reset outputs",
                {29'b0, ack, err, ext_cyc}, 0);
            chk(ext_wstb_n === 4'hF, "R11 reset strobes", {28'b0, ext_wstb_n}, 32'hF);
            mode_pin = ~e[0];
            for (int i = 0; i < 64; i++) begin
                mem[i] = 8'((i * 37 + 5) ^ (e * 8'h5A));
                ref_mem[i] = mem[i];
            end
            // R1: pin flipped after reset, a byte write at offset 0 of a
            // 32-bit device must still use the lane of the latched order
            dev_width = 2'b10; w_b = 4;
            @(negedge clk);
            req = 1; req_size = 2'd0; req_addr = 16; req_we = 1; req_wdata = 32'h5A;
            @(negedge clk);
            req = 0;
            chk(ext_wstb_n === (be_b ? 4'b0111 : 4'b1110), "R1 latched byte order",
                {28'b0, ext_wstb_n}, be_b ? 32'h7 : 32'hE);
            @(negedge clk);
            @(negedge clk);
            for (int dw = 0; dw < 4; dw++) begin
                dev_width = 2'(dw);
                w_b = (dw == 0) ? 1 : (dw == 1) ? 2 : 4;
                for (int sz = 0; sz < 4; sz++) begin
                    for (int off = 0; off < 8; off++) begin
                        v = 32'h9C3A_51E7 ^ (32'(e) << 28) ^ (32'(dw) << 20)
                            ^ (32'(sz) << 12) ^ (32'(off) * 32'h0103_0507);
                        do_op(sz, 16 + off, 1'b1, v, 1'b0);
                        do_op(sz, 16 + off, 1'b0, 32'h0, 1'b0);
                    end
                end
            end
            dev_width = 2'b00; w_b = 1;
            do_op(2, 32, 1'b0, 32'h0, 1'b1);
        end
        finish_up();
    end
endmodule